// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines, resolves them by fixed priority and presents one interrupt signal to a processor. Software reaches it through a two-port register window chosen by a single address bit. Port 0 takes commands and returns status. Port 1 takes configuration bytes while a setup sequence is running; otherwise it reaches the mask register. After the processor pulses an acknowledge input, the block returns an 8-bit vector. The upper bits of that vector are the programmed base, and the low three bits give the line being serviced.

A command-sequencing state machine gives each write its meaning. A command byte with bit 4 set starts a setup sequence of up to four words. That byte chooses single or cascade operation, edge or level sensing, and whether a final mode word will follow. The data bytes after it fill in the vector base, the cascade byte (skipped in single mode) and the mode word. Once the sequence is over, data-port writes load the mask, and command-port writes either end interrupt service or choose which status register the command port returns on reads. The cascade byte is driven out unchanged so that surrounding logic can use it.

Top module: `intctl8_top`

## Requirements
- R1: After reset, cpu_int_o and vec_vld_o are 0, the mask register is 0xFF, the cascade byte is 0x00, edge sensing and manual end-of-service are in force, the status read selects the request register, and no setup sequence is in progress.
- R2: A command-port write with bit 4 set starts a setup sequence. That byte's bit 0 asks for a mode word, bit 1 chooses single mode and bit 3 chooses level sensing. The same write clears the mask, the in-service and request registers, automatic end-of-service and the status read select (which goes back to the request register).
- R3: Data-port writes during setup are taken in this order: the base word, then the cascade byte (skipped in single mode), then the mode word if one was asked for. The cascade byte appears on casc_cfg_o and is left unchanged when its step is skipped.
- R4: The vector is the upper 5 bits of the base word followed by the 3-bit number of the serviced line.
- R5: When mode-word bit 1 is set, an acknowledge leaves the in-service register unchanged (automatic end of service).
- R6: Outside setup, a data-port write loads the mask register and a data-port read returns it. A mask bit of 1 stops its line from raising cpu_int_o or from being serviced.
- R7: Line 0 has the highest priority. cpu_int_o is set one cycle after the lowest-numbered unmasked pending line is found to be lower in number than every in-service line, or when no line is in service.
- R8: vec_vld_o pulses in the cycle after ack_i, and vector_o holds the vector from that cycle on. An acknowledged line moves from the request register into the in-service register.
- R9: Outside setup, command 0x60|n clears in-service bit n, and command 0x20 clears the lowest-numbered in-service bit. Any other value with bits 4 and 3 clear has no effect, and command writes without bit 4 are ignored during setup.
- R10: Outside setup, command 0x0A makes later command-port reads return the request register, and 0x0B makes them return the in-service register. rdata_o is loaded in the cycle after a read strobe.
- R11: If ack_i comes when no line qualifies under R7, the vector carries line 7 and the in-service register is left as it was.
- R12: In edge mode a request is latched on a rising input, is dropped if the input falls, and is cleared by its acknowledge; an input held high does not ask again. In level mode the request register follows the inputs.
- R13: When an acknowledge and an end-of-service command arrive in the same cycle, the end-of-service acts on the in-service register as it stood before that acknowledge, and the bit set by the acknowledge remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = command port, 1 = data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_i | input | 8 | Interrupt request lines |
| cpu_int_o | output | 1 | Interrupt to processor |
| ack_i | input | 1 | Acknowledge pulse from processor |
| vec_vld_o | output | 1 | Vector valid, one cycle after ack_i |
| vector_o | output | 8 | Delivered vector |
| casc_cfg_o | output | 8 | Programmed cascade byte |

## Verification
Acknowledge and end-of-service both modify the in-service register, and they can fall in the same clock cycle. The bench provokes this by raising a higher-priority line while a lower-priority one is in service, then driving ack_i together with a non-specific end-of-service command. It judges the result by reading back the in-service register: the older bit must be cleared and the newly granted bit kept. A behavioural model runs alongside the design and compares cpu_int_o, the vector, the read data and the cascade byte on every clock.

// File: rtl/intctl8_pkg.sv
package intctl8_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  // command byte bit positions
  localparam int CB_START   = 4;
  localparam int CB_STATSEL = 3;
  localparam int CB_NEED4   = 0;
  localparam int CB_SINGLE  = 1;
  localparam int CB_LEVEL   = 3;
  localparam int CB_RDVALID = 1;
  localparam int CB_RDISR   = 0;
  localparam int MW_AUTO    = 1;

  localparam logic [2:0] EOI_SPEC = 3'b011;
  localparam logic [2:0] EOI_ANY  = 3'b001;
endpackage

// File: rtl/intctl8_prio.sv
module intctl8_prio #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/intctl8_req.sv
module intctl8_req #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_i,
  input  logic         level_i,
  input  logic         clr_all_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        irr_o[g]  <= 1'b0;
      end else begin
        prev_q[g] <= irq_i[g];
        if (clr_all_i)
          irr_o[g] <= 1'b0;
        else if (level_i)
          irr_o[g] <= irq_i[g];
        else
          irr_o[g] <= (irr_o[g] | (irq_i[g] & ~prev_q[g])) & irq_i[g] & ~take_i[g];
      end
    end
  end
endmodule

// File: rtl/intctl8_cfg.sv
module intctl8_cfg
  import intctl8_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic [BW-1:0] base_o,
  output logic [DW-1:0] casc_o,
  output logic          level_o,
  output logic          aeoi_o,
  output logic          rsel_o,
  output logic          init_o,
  output logic          eoi_sp_o,
  output logic          eoi_ns_o,
  output logic [LW-1:0] eoi_line_o
);
  seq_e state_q;
  logic single_q, need4_q;
  logic cmd_wr, dat_wr, ocw_ok;

  assign cmd_wr     = wr_en_i && !addr_i;
  assign dat_wr     = wr_en_i && addr_i;
  assign init_o     = cmd_wr && wdata_i[CB_START];
  assign ocw_ok     = cmd_wr && !wdata_i[CB_START] && (state_q == SEQ_RUN);
  assign eoi_sp_o   = ocw_ok && !wdata_i[CB_STATSEL] && (wdata_i[DW-1:DW-3] == EOI_SPEC);
  assign eoi_ns_o   = ocw_ok && !wdata_i[CB_STATSEL] && (wdata_i[DW-1:DW-3] == EOI_ANY);
  assign eoi_line_o = wdata_i[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_RUN;
      mask_o   <= '1;
      base_o   <= '0;
      casc_o   <= '0;
      level_o  <= 1'b0;
      aeoi_o   <= 1'b0;
      rsel_o   <= 1'b0;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (init_o) begin
      state_q  <= SEQ_BASE;
      single_q <= wdata_i[CB_SINGLE];
      level_o  <= wdata_i[CB_LEVEL];
      need4_q  <= wdata_i[CB_NEED4];
      aeoi_o   <= 1'b0;
      mask_o   <= '0;
      rsel_o   <= 1'b0;
    end else if (ocw_ok && wdata_i[CB_STATSEL] && wdata_i[CB_RDVALID]) begin
      rsel_o <= wdata_i[CB_RDISR];
    end else if (dat_wr) begin
      unique case (state_q)
        SEQ_BASE: begin
          base_o <= wdata_i[DW-1:LW];
          if (!single_q)    state_q <= SEQ_CASC;
          else if (need4_q) state_q <= SEQ_MODE;
          else              state_q <= SEQ_RUN;
        end
        SEQ_CASC: begin
          casc_o  <= wdata_i;
          state_q <= need4_q ? SEQ_MODE : SEQ_RUN;
        end
        SEQ_MODE: begin
          aeoi_o  <= wdata_i[MW_AUTO];
          state_q <= SEQ_RUN;
        end
        default: mask_o <= wdata_i;
      endcase
    end
  end
endmodule

// File: rtl/intctl8_top.sv
module intctl8_top #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW),
  localparam int BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irq_i,
  output logic          cpu_int_o,
  input  logic          ack_i,
  output logic          vec_vld_o,
  output logic [DW-1:0] vector_o,
  output logic [DW-1:0] casc_cfg_o
);
  logic [DW-1:0] mask_w, irr_w, isr_q, pend_w, take_w, eoi_clr, set_w;
  logic [BW-1:0] base_w;
  logic          level_w, aeoi_w, rsel_w, init_w, eoi_sp_w, eoi_ns_w;
  logic [LW-1:0] eoi_line_w, pend_idx, isr_idx;
  logic          pend_any, isr_any, grant_ok, take_now;

  intctl8_cfg #(.DW(DW)) cfg_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .mask_o(mask_w), .base_o(base_w), .casc_o(casc_cfg_o), .level_o(level_w),
    .aeoi_o(aeoi_w), .rsel_o(rsel_w), .init_o(init_w), .eoi_sp_o(eoi_sp_w),
    .eoi_ns_o(eoi_ns_w), .eoi_line_o(eoi_line_w)
  );

  intctl8_req #(.N(DW)) req_i (
    .clk(clk), .rst(rst), .irq_i(irq_i), .level_i(level_w), .clr_all_i(init_w),
    .take_i(take_w), .irr_o(irr_w)
  );

  assign pend_w = irr_w & ~mask_w;

  intctl8_prio #(.N(DW)) pend_prio_i (.vec_i(pend_w), .any_o(pend_any), .idx_o(pend_idx));
  intctl8_prio #(.N(DW)) isr_prio_i  (.vec_i(isr_q),  .any_o(isr_any),  .idx_o(isr_idx));

  assign grant_ok = pend_any && (!isr_any || (pend_idx < isr_idx));
  assign take_now = ack_i && grant_ok;
  assign take_w   = take_now ? (DW'(1) << pend_idx) : '0;
  assign set_w    = aeoi_w ? '0 : take_w;

  always_comb begin
    eoi_clr = '0;
    if (eoi_sp_w)                eoi_clr = DW'(1) << eoi_line_w;
    else if (eoi_ns_w && isr_any) eoi_clr = DW'(1) << isr_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= '0;
      cpu_int_o <= 1'b0;
      vec_vld_o <= 1'b0;
      vector_o  <= '0;
      rdata_o   <= '0;
    end else begin
      cpu_int_o <= grant_ok;
      vec_vld_o <= ack_i;
      if (ack_i) vector_o <= {base_w, take_now ? pend_idx : {LW{1'b1}}};
      if (rd_en_i) rdata_o <= addr_i ? mask_w : (rsel_w ? isr_q : irr_w);
      if (init_w) isr_q <= '0;
      else        isr_q <= (isr_q & ~eoi_clr) | set_w;
    end
  end
endmodule

// File: rtl/intctl8_chk.sv
module intctl8_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_i,
  input logic          cpu_int_o,
  input logic          vec_vld_o,
  input logic [DW-1:0] isr,
  input logic [DW-1:0] irr,
  input logic [DW-1:0] mask,
  input logic          aeoi
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_int_o && !vec_vld_o));
  // R7
  int_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_int_o |-> $past(|(irr & ~mask)));
  // R6
  masked_not_served_chk: assert property (@(posedge clk) disable iff (rst)
    ((isr & ~$past(isr)) & $past(mask)) == '0);
  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(isr & ~$past(isr)) <= 1);
  // R8
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    vec_vld_o |-> $past(ack_i));
  // R5
  auto_eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (aeoi && isr == '0) |=> (isr == '0));
endmodule

bind intctl8_top intctl8_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .ack_i(ack_i), .cpu_int_o(cpu_int_o), .vec_vld_o(vec_vld_o),
  .isr(isr_q), .irr(irr_w), .mask(mask_w), .aeoi(aeoi_w)
);

// File: tb/intctl8_top_tb_top.sv
`timescale 1ns/1ps
module intctl8_top_tb_top;
  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, addr = 0, ack = 0;
  logic [7:0] wdata = 0, irq = 0;
  logic [7:0] rdata, vector, casc;
  logic cpu_int, vec_vld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intctl8_top dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .cpu_int_o(cpu_int),
    .ack_i(ack), .vec_vld_o(vec_vld), .vector_o(vector), .casc_cfg_o(casc)
  );

  // behavioural reference
  int m_state;
  logic [7:0] m_mask, m_casc, m_isr, m_irr, m_prev, m_vec, m_rd, m_base;
  logic m_single, m_need4, m_level, m_aeoi, m_rsel, m_int, m_vv;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_mask = 8'hFF; m_casc = 0; m_isr = 0; m_irr = 0; m_prev = 0;
      m_vec = 0; m_rd = 0; m_base = 0; m_single = 0; m_need4 = 0; m_level = 0;
      m_aeoi = 0; m_rsel = 0; m_int = 0; m_vv = 0;
    end else begin
      int pi, ii;
      bit ok, init, ocw;
      logic [7:0] clr, takeb;
      pi = lowest(m_irr & ~m_mask);
      ii = lowest(m_isr);
      ok = (pi < 8) && (pi < ii);
      init = wr_en && !addr && wdata[4];
      ocw = wr_en && !addr && !wdata[4] && (m_state == 0);
      clr = 0;
      if (ocw && !wdata[3] && wdata[7:5] == 3'd3) clr = 8'd1 << wdata[2:0];
      if (ocw && !wdata[3] && wdata[7:5] == 3'd1 && ii < 8) clr = 8'd1 << ii;
      takeb = (ack && ok) ? (8'd1 << pi) : 8'd0;
      if (rd_en) m_rd = addr ? m_mask : (m_rsel ? m_isr : m_irr);
      if (ack) m_vec = {m_base[7:3], ok ? 3'(pi) : 3'd7};
      m_vv = ack;
      m_int = ok;
      if (init) m_isr = 0;
      else m_isr = (m_isr & ~clr) | (m_aeoi ? 8'd0 : takeb);
      if (init) m_irr = 0;
      else if (m_level) m_irr = irq;
      else m_irr = (m_irr | (irq & ~m_prev)) & irq & ~takeb;
      m_prev = irq;
      if (init) begin
        m_state = 1; m_single = wdata[1]; m_level = wdata[3]; m_need4 = wdata[0];
        m_aeoi = 0; m_mask = 0; m_rsel = 0;
      end else if (ocw && wdata[3] && wdata[1]) begin
        m_rsel = wdata[0];
      end else if (wr_en && addr) begin
        case (m_state)
          1: begin m_base = wdata; m_state = !m_single ? 2 : (m_need4 ? 3 : 0); end
          2: begin m_casc = wdata; m_state = m_need4 ? 3 : 0; end
          3: begin m_aeoi = wdata[1]; m_state = 0; end
          default: m_mask = wdata;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 cpu_int model", {7'd0, cpu_int}, {7'd0, m_int});
      chk("R8 vec_vld model", {7'd0, vec_vld}, {7'd0, m_vv});
      if (vec_vld) chk("R4 vector model", vector, m_vec);
      chk("R10 rdata model", rdata, m_rd);
      chk("R3 casc model", casc, m_casc);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #2; wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2; wr_en = 0;
  endtask
  task automatic rd(input logic a);
    @(posedge clk); #2; rd_en = 1; addr = a;
    @(posedge clk); #2; rd_en = 0;
  endtask
  task automatic do_ack();
    @(posedge clk); #2; ack = 1;
    @(posedge clk); #2; ack = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1
    chk("R1 cpu_int after reset", {7'd0, cpu_int}, 8'd0);
    chk("R1 casc after reset", casc, 8'h00);
    rd(1); chk("R1 mask after reset", rdata, 8'hFF);

    // R2 R3 cascade setup with mode word
    wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    chk("R3 cascade byte", casc, 8'h04);
    rd(1); chk("R2 mask cleared by setup", rdata, 8'h00);

    // R7 R8 R4
    irq = 8'h28; idle(3);
    chk("R7 int raised", {7'd0, cpu_int}, 8'd1);
    do_ack(); chk("R4 vector line3", vector, 8'h23);
    wr(0, 8'h0B); rd(0); chk("R8 isr after ack", rdata, 8'h08);
    idle(2); chk("R7 lower prio blocked", {7'd0, cpu_int}, 8'd0);
    wr(0, 8'h0A); rd(0); chk("R12 edge no rerequest", rdata, 8'h20);
    wr(0, 8'h0B); wr(0, 8'h20); rd(0); chk("R9 nonspecific eoi", rdata, 8'h00);
    idle(2); chk("R7 next line raised", {7'd0, cpu_int}, 8'd1);
    do_ack(); chk("R4 vector line5", vector, 8'h25);

    // R13 ack and eoi together
    irq = 8'h2A; idle(3);
    chk("R7 higher prio preempts", {7'd0, cpu_int}, 8'd1);
    @(posedge clk); #2; ack = 1; wr_en = 1; addr = 0; wdata = 8'h20;
    @(posedge clk); #2; ack = 0; wr_en = 0;
    chk("R13 vector line1", vector, 8'h21);
    rd(0); chk("R13 isr after collision", rdata, 8'h02);
    wr(0, 8'h41); rd(0); chk("R9 unknown command ignored", rdata, 8'h02);
    wr(0, 8'h61); rd(0); chk("R9 specific eoi", rdata, 8'h00);

    // R6 masking
    irq = 8'h00; idle(2);
    wr(1, 8'h01); irq = 8'h01; idle(3);
    chk("R6 masked line silent", {7'd0, cpu_int}, 8'd0);
    rd(1); chk("R6 mask readback", rdata, 8'h01);
    wr(1, 8'h00); idle(2);
    chk("R6 unmasked line raises", {7'd0, cpu_int}, 8'd1);

    // R11 spurious
    irq = 8'h00; idle(1);
    do_ack(); chk("R11 spurious vector", vector, 8'h27);
    rd(0); chk("R11 isr untouched", rdata, 8'h00);

    // R2 R3 R5 R9 R12 single, level, automatic end of service
    wr(1, 8'hF0); irq = 8'h04;
    wr(0, 8'h1B); wr(0, 8'h0B); wr(1, 8'h48); wr(1, 8'h03);
    chk("R3 cascade kept when skipped", casc, 8'h04);
    rd(1); chk("R2 mask cleared again", rdata, 8'h00);
    rd(0); chk("R9 command ignored during setup", rdata, 8'h04);
    idle(1); chk("R12 level request", {7'd0, cpu_int}, 8'd1);
    do_ack(); chk("R4 vector new base", vector, 8'h4A);
    wr(0, 8'h0B); rd(0); chk("R5 auto end of service", rdata, 8'h00);
    chk("R12 level keeps int", {7'd0, cpu_int}, 8'd1);
    irq = 8'h00; idle(3);
    chk("R12 level drop", {7'd0, cpu_int}, 8'd0);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule